// File: doc/BRIEF.md
# Windowed Program-Memory Bank Mapper

This block sits between an 8-bit CPU with a 16-bit address bus and a program ROM that is larger than the CPU can address directly. It divides the upper half of CPU space ($8000-$FFFF) into four switchable windows. Three are 8 KiB ($8000, $A000, $C000). The fourth is a 4 KiB window at $E000-$EFFF. Above it, $F000-$FFFF is pinned to the last 4 KiB of ROM, so reset and interrupt vectors always live in a known place.

Each window has its own bank register. A CPU store anywhere in a window loads that window's register. There is no separate index register: CPU address bits 14 and 13 pick the register for both loading and lookup. The upper ROM address bits are the looked-up bank number, ORed with a flag that is set when A14, A13 and A12 are all high. ROM address bits 12..0 follow the CPU address unchanged.

With the default 4-bit bank number the block reaches 128 KiB of ROM. Setting the bank-width parameter to 8 reaches 2 MiB.

Top module: `prg_window_mapper`

## Requirements
- R1: After reset every bank register holds zero, so a read in any of the four windows yields bank 0.
- R2: A cycle with `cpu_rnw` = 0 and `cpu_addr[15]` = 1 loads `cpu_data[BANK_W-1:0]` into the register chosen by `cpu_addr[14:13]` on that clock edge. Window 0 is 00 ($8000), window 1 is 01 ($A000), window 2 is 10 ($C000) and window 3 is 11 ($E000). The new value appears on `rom_addr` from the next cycle.
- R3: A write cycle with `cpu_addr[15]` = 0 changes no bank register.
- R4: A read cycle (`cpu_rnw` = 1) changes no bank register, whatever its address.
- R5: Outside $F000-$FFFF, `rom_addr[ROM_AW-1:13]` equals the register chosen by `cpu_addr[14:13]`.
- R6: When `cpu_addr[14:12]` = 111, `rom_addr[ROM_AW-1:13]` is all ones, whatever the register contents.
- R7: Reads in $E000-$EFFF use register 3 with `rom_addr[12]` = 0, so they see the lower half of the selected 8 KiB bank.
- R8: `rom_addr[12:0]` always equals `cpu_addr[12:0]`.
- R9: `rom_oe_n` is 0 exactly when `cpu_addr[15]` = 1 and `cpu_rnw` = 1, and is 1 otherwise.
- R10: A register is loaded by a write to any address in its window. For example, a write to $BFFF loads register 1.
- R11: Data bits above `BANK_W-1` are ignored when a register is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-synchronous clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus (store data) |
| cpu_rnw | input | 1 | 1 = read cycle, 0 = write cycle |
| rom_addr | output | 13+BANK_W | Extended program ROM address |
| rom_oe_n | output | 1 | Active-low ROM output enable |

## Verification
The assertions assume that the address, data and direction inputs are steady around each rising clock edge. They also assume that exactly one bus cycle is presented per clock, so the write strobe is simply `cpu_rnw` low qualified by A15. The stimulus changes inputs only on the falling edge and holds them for a full period.

Writes go to mirrored offsets, to addresses below $8000 and with junk in the high data bits. Each window is read at its first, middle and last addresses. The fixed region is read while register 3 holds both all-zero and non-zero values.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
    // Number of switchable windows and index width
    localparam int WIN_CNT   = 4;
    localparam int WIN_SEL_W = 2;
    // CPU address bits that pass straight to the ROM
    localparam int OFFS_W    = 13;
    localparam int CPU_AW    = 16;
    localparam int CPU_DW    = 8;

    typedef logic [WIN_SEL_W-1:0] win_idx_t;
endpackage

// File: rtl/map_bus_decode.sv
module map_bus_decode
    import mapper_pkg::*;
(
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rnw,
    output logic              bank_we,
    output win_idx_t          win_idx,
    output logic              fixed_hit,
    output logic              oe_n
);
    always_comb begin
        // Store to the upper half of CPU space targets the bank registers
        bank_we   = cpu_addr[15] & ~cpu_rnw;
        win_idx   = cpu_addr[14:13];
        // Top 4 KiB of the CPU space is the pinned region
        fixed_hit = cpu_addr[14] & cpu_addr[13] & cpu_addr[12];
        oe_n      = ~(cpu_addr[15] & cpu_rnw);
    end
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
    import mapper_pkg::*;
#(
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  win_idx_t          idx,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] rdata
);
    typedef struct packed {
        logic [WIN_CNT-1:0][BANK_W-1:0] entry;
    } rf_state_t;

    rf_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (we) begin
            state_d.entry[idx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // The same two address bits index the read port
    assign rdata = state_q.entry[idx];

    // R2: a store lands in the addressed entry
    assert_store_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (state_q.entry[$past(idx)] == $past(wdata)));

    // R4: entries hold whenever no store is strobed
    assert_hold_no_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(state_q));
endmodule

// File: rtl/rom_addr_form.sv
module rom_addr_form
    import mapper_pkg::*;
#(
    parameter int BANK_W = 4,
    localparam int ROM_AW = OFFS_W + BANK_W
) (
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              fixed_hit,
    input  logic [OFFS_W-1:0] cpu_offs,
    output logic [ROM_AW-1:0] rom_addr
);
    logic [BANK_W-1:0] bank_eff;

    always_comb begin
        // Forcing every bank bit high selects the final ROM bank
        bank_eff = bank_sel | {BANK_W{fixed_hit}};
        rom_addr = {bank_eff, cpu_offs};
    end
endmodule

// File: rtl/prg_window_mapper.sv
module prg_window_mapper
    import mapper_pkg::*;
#(
    parameter int BANK_W = 4,
    localparam int ROM_AW = OFFS_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_rnw,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_oe_n
);
    logic              bank_we;
    win_idx_t          win_idx;
    logic              fixed_hit;
    logic [BANK_W-1:0] bank_sel;

    generate
        if (BANK_W < CPU_DW) begin : g_narrow
            // High data bits carry no bank information in the narrow variant
            logic unused_data_hi;
            assign unused_data_hi = ^cpu_data[CPU_DW-1:BANK_W];
        end
    endgenerate

    map_bus_decode u_dec (
        .cpu_addr  (cpu_addr),
        .cpu_rnw   (cpu_rnw),
        .bank_we   (bank_we),
        .win_idx   (win_idx),
        .fixed_hit (fixed_hit),
        .oe_n      (rom_oe_n)
    );

    bank_regfile #(.BANK_W(BANK_W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .idx   (win_idx),
        .wdata (cpu_data[BANK_W-1:0]),
        .rdata (bank_sel)
    );

    rom_addr_form #(.BANK_W(BANK_W)) u_form (
        .bank_sel  (bank_sel),
        .fixed_hit (fixed_hit),
        .cpu_offs  (cpu_addr[OFFS_W-1:0]),
        .rom_addr  (rom_addr)
    );

    // R3: stores below the upper half never strobe the register file
    assert_low_store_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_addr[15] |-> !bank_we);

    // R6: the pinned region always yields the all-ones bank
    assert_fixed_all_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[14:12] == 3'b111) |-> (&rom_addr[ROM_AW-1:OFFS_W]));

    // R8: offset bits pass through unchanged
    assert_offset_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rom_addr[OFFS_W-1:0] == cpu_addr[OFFS_W-1:0]);

    // R9: ROM is enabled only on reads of the upper half
    assert_oe_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> (cpu_addr[15] && cpu_rnw));

    // R7: window 3 reads land in the lower half of the chosen bank
    assert_win3_low_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:12] == 4'hE) |-> !rom_addr[12]);
endmodule

// File: tb/sim_prg_window_mapper.sv
module sim_prg_window_mapper;
    localparam int BW  = 4;
    localparam int RAW = 13 + BW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [15:0]    cpu_addr = 16'h0000;
    logic [7:0]     cpu_data = 8'h00;
    logic           cpu_rnw = 1'b1;
    logic [RAW-1:0] rom_addr;
    logic           rom_oe_n;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;
    int model_bank [4];

    always #10 clk = ~clk;  // 50 MHz

    prg_window_mapper #(.BANK_W(BW)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .cpu_rnw  (cpu_rnw),
        .rom_addr (rom_addr),
        .rom_oe_n (rom_oe_n)
    );

    // One bus cycle: drive on falling edge, compare mid-low, update model at rising edge
    task automatic cycle(input logic [15:0] a, input logic [7:0] d, input logic rnw,
                         input string req);
        logic [RAW-1:0] exp_addr;
        logic           exp_oe;
        int             upper;
        @(negedge clk);
        cpu_addr = a;
        cpu_data = d;
        cpu_rnw  = rnw;
        #5;
        if (a[14:12] == 3'b111) upper = (1 << BW) - 1;
        else upper = model_bank[a[14:13]];
        exp_addr = RAW'((upper << 13) | int'(a[12:0]));
        exp_oe   = !(a[15] && rnw);
        vectors++;
        if (rom_addr !== exp_addr || rom_oe_n !== exp_oe) begin
            miscompares++;
            $display("FAIL %s addr=%h rnw=%0b: rom_addr=%h oe_n=%b expected rom_addr=%h oe_n=%b",
                     req, a, rnw, rom_addr, rom_oe_n, exp_addr, exp_oe);
        end
        @(posedge clk);
        if (!rnw && a[15]) model_bank[a[14:13]] = int'(d) & ((1 << BW) - 1);
    endtask

    task automatic rd(input logic [15:0] a, input string req);
        cycle(a, 8'h00, 1'b1, req);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string req);
        cycle(a, d, 1'b0, req);
    endtask

    task automatic all_windows(input string req);
        rd(16'h8000, req); rd(16'h9FFF, req);
        rd(16'hA000, req); rd(16'hB5A5, req);
        rd(16'hC000, req); rd(16'hDFFF, req);
        rd(16'hE000, req); rd(16'hEFFF, req);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) model_bank[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents are zero in every window
        all_windows("R1");

        // R2 / R5: distinct value per window
        wr(16'h8000, 8'h03, "R2");
        wr(16'hA000, 8'h05, "R2");
        wr(16'hC000, 8'h09, "R2");
        wr(16'hE000, 8'h0C, "R2");
        all_windows("R5");

        // R7: window 3 sees the lower half of its bank
        rd(16'hE800, "R7"); rd(16'hE001, "R7");

        // R6: pinned region with non-zero and zero register 3
        rd(16'hF000, "R6"); rd(16'hFFFC, "R6"); rd(16'hF7FF, "R6");
        wr(16'hE123, 8'h00, "R6");
        rd(16'hF000, "R6"); rd(16'hFFFF, "R6"); rd(16'hE000, "R6");

        // R10: mirrored store addresses
        wr(16'hBFFF, 8'h07, "R10");
        rd(16'hA123, "R10");
        wr(16'h9ABC, 8'h0A, "R10");
        rd(16'h8000, "R10");
        wr(16'hDD00, 8'h01, "R10");
        rd(16'hC777, "R10");

        // R11: upper data bits dropped
        wr(16'h8000, 8'hF6, "R11");
        rd(16'h8800, "R11");
        wr(16'hF000, 8'hBE, "R11");
        rd(16'hE000, "R11"); rd(16'hF000, "R11");

        // R3: stores below $8000 are ignored
        wr(16'h0000, 8'h0F, "R3");
        wr(16'h2000, 8'h0F, "R3");
        wr(16'h4000, 8'h0F, "R3");
        wr(16'h7FFF, 8'h0F, "R3");
        all_windows("R3");

        // R4: reads never change registers, including high data on bus
        for (int k = 0; k < 16; k++) cycle(16'h8000 + 16'(k * 16'h0801), 8'hFF, 1'b1, "R4");
        all_windows("R4");

        // R9: enable qualification, R8: offset pass-through
        rd(16'h0123, "R9"); rd(16'h7FFF, "R9");
        wr(16'h8000, 8'h02, "R9");
        rd(16'h8000, "R9");
        for (int k = 0; k < 13; k++) rd(16'h8000 | 16'(1 << k), "R8");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule